// File: doc/BRIEF.md
# Compiler-Managed Instruction Register File

This block is a small, software-placed instruction store that feeds the fetch stage in place of the instruction cache. Code runs from its slots, so a hot loop never touches the cache arrays. There is no tag lookup and no hardware replacement. Software chooses the destination slots. It issues a transfer command with a backing-memory start address, a destination slot base and a length. A transfer engine then copies that block into the slots, one instruction per response cycle, while fetch keeps running from other slots.

Software can issue a transfer as soon as it knows which block comes next, well ahead of that block's first use. Each slot has a valid bit. The bit is cleared when the transfer that targets the slot starts, and it is set when the slot is written. Fetch from a slot that is not yet valid stalls on that slot until the data arrives. One further command can wait in a single-entry queue behind the active transfer.

The fetch sequencer holds a slot index and steps through the slots. For a loop, software gives a start slot and an end slot. The index then returns from the end slot to the start slot, and only that slot range is enabled for fetch. The default store has 64 slots. The slot count must be a power of two, so that slot arithmetic wraps naturally.

Top module: `irf_top`

## Requirements
- R1: After reset, all slots are invalid, `busy` is 0, `cmd_ready` is 1, `fetch_slot` is 0 and `fetch_valid` is 0.
- R2: When a command starts, it clears the valid bit of each slot in `base .. base+len-1` (modulo the slot count) at that clock edge. Slots outside this range keep their valid bit and contents.
- R3: A started transfer issues exactly `len` read requests on `mem_req`, at consecutive addresses from the command address, at most one per cycle. The k-th in-order response (`mem_rvalid`, `mem_rdata`) is written to slot `(base+k)` modulo the slot count and makes that slot valid.
- R4: `busy` rises at the edge that accepts a command. It stays high until the edge that writes the last response of the last accepted command. With a response latency of two cycles, a lone transfer of length L keeps `busy` high for L+2 cycles.
- R5: While a transfer runs, one more command is accepted into a queue, and `cmd_ready` stays 0 while the queue is full. A command offered while `cmd_ready` is 0 is ignored. The queued command starts on the cycle after the active transfer's last write.
- R6: `fetch_valid` is 1 and `fetch_instr` carries the contents of slot `fetch_slot` when `fetch_en` is 1 and the slot is valid and enabled. If the slot is invalid, `fetch_valid` is 0 and `fetch_slot` holds its value.
- R7: Each cycle with `fetch_valid` and no redirect, the index advances by one modulo the slot count. If `loop_on` is 1 and the index equals `loop_end`, it returns to `loop_start` instead.
- R8: `redirect` loads `redirect_slot` into the index at the next edge. It takes priority over the step and the stall.
- R9: With `loop_on` at 1, `active_mask` has exactly bits `loop_start..loop_end` set, where `loop_start` must not exceed `loop_end`. Fetch from a slot outside that range gives `fetch_valid` 0. With `loop_on` at 0, all bits are set.
- R10: A command with length 0 is discarded. It does not start a transfer, does not raise `busy` and clears no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Transfer command offered |
| cmd_addr | input | AW | Backing-memory start address |
| cmd_base | input | log2(NSLOT) | First destination slot |
| cmd_len | input | log2(NSLOT)+1 | Number of instructions, 1..NSLOT |
| cmd_ready | output | 1 | Queue can take a command |
| busy | output | 1 | A transfer is active or queued |
| mem_req | output | 1 | Backing-memory read request |
| mem_addr | output | AW | Read address |
| mem_rvalid | input | 1 | In-order read response valid |
| mem_rdata | input | IW | Read response data |
| fetch_en | input | 1 | Fetch stage wants an instruction |
| redirect | input | 1 | Load a new fetch index |
| redirect_slot | input | log2(NSLOT) | Slot to redirect to |
| loop_on | input | 1 | Loop partition active |
| loop_start | input | log2(NSLOT) | First slot of the loop |
| loop_end | input | log2(NSLOT) | Last slot of the loop |
| fetch_valid | output | 1 | Instruction delivered this cycle |
| fetch_slot | output | log2(NSLOT) | Current fetch index |
| fetch_instr | output | IW | Contents of the current slot |
| active_mask | output | NSLOT | Slots enabled by the partition |

## Verification
The in-module assertions check several rules on every cycle. A clear at start always wins over a write in the same cycle, and a write sets its slot valid. A queued command stays frozen while it waits, and responses arrive only during a transfer. The fetch index holds on a stall, steps, wraps at the loop end and obeys a redirect. `busy` falls only on a write cycle. Other properties only the bench scenarios can show. These are the data actually landing in the right slots for every base value, including ranges that wrap. They also include the exact stall length before a freshly loaded slot becomes readable, the ignored third command, the timing of queue promotion, and the sequence of slots fetched inside a loop.

// File: rtl/irf_pkg.sv
package irf_pkg;

    localparam int IRF_SLOTS_DEF   = 64;
    localparam int IRF_ADDR_W_DEF  = 16;
    localparam int IRF_INSTR_W_DEF = 32;

    typedef enum logic [0:0] {
        XF_IDLE,
        XF_RUN
    } xf_state_e;

    typedef enum logic [1:0] {
        PC_HOLD,
        PC_STEP,
        PC_WRAP,
        PC_JUMP
    } pc_act_e;

    // distance from base to idx walking upward around a ring of n slots
    function automatic int ring_dist(input int idx, input int base, input int n);
        return ((idx - base) % n + n) % n;
    endfunction

    function automatic logic in_window(input int idx, input int lo, input int hi);
        return (idx >= lo) && (idx <= hi);
    endfunction

endpackage

// File: rtl/irf_xfer.sv
module irf_xfer
    import irf_pkg::*;
#(
    parameter int NSLOT = IRF_SLOTS_DEF,
    parameter int AW    = IRF_ADDR_W_DEF,
    localparam int SW   = $clog2(NSLOT),
    localparam int LW   = SW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [SW-1:0]    cmd_base,
    input  logic [LW-1:0]    cmd_len,
    output logic             cmd_ready,
    output logic             busy,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    output logic             wr_en,
    output logic [SW-1:0]    wr_slot,
    output logic [NSLOT-1:0] clr_mask
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [SW-1:0] base;
        logic [LW-1:0] len;
    } xcmd_t;

    xf_state_e     state;
    xcmd_t         cur;
    xcmd_t         pend;
    xcmd_t         inc;
    xcmd_t         nxt;
    logic          pend_v;
    logic [LW-1:0] req_cnt;
    logic [LW-1:0] rcv_cnt;
    logic          cmd_ok;
    logic          start_pend;
    logic          start_new;
    logic          take_q;
    logic          start;
    logic          last_rsp;
    logic          running;

    assign running    = (state == XF_RUN);
    assign inc        = '{addr: cmd_addr, base: cmd_base, len: cmd_len};
    assign cmd_ok     = cmd_valid && (cmd_len != '0) && !pend_v;
    assign start_pend = !running && pend_v;
    assign start_new  = !running && cmd_ok;
    assign take_q     = running && cmd_ok;
    assign start      = start_pend || start_new;
    assign nxt        = start_pend ? pend : inc;
    assign last_rsp   = running && mem_rvalid && (rcv_cnt == cur.len - LW'(1));

    // clear every slot the starting transfer will overwrite
    for (genvar i = 0; i < NSLOT; i++) begin : g_clr
        assign clr_mask[i] = start && (ring_dist(i, int'(nxt.base), NSLOT) < int'(nxt.len));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= XF_IDLE;
            cur     <= '0;
            pend    <= '0;
            pend_v  <= 1'b0;
            req_cnt <= '0;
            rcv_cnt <= '0;
        end else begin
            if (start) begin
                state   <= XF_RUN;
                cur     <= nxt;
                req_cnt <= '0;
                rcv_cnt <= '0;
            end else if (running) begin
                if (mem_req)    req_cnt <= req_cnt + LW'(1);
                if (mem_rvalid) rcv_cnt <= rcv_cnt + LW'(1);
                if (last_rsp)   state   <= XF_IDLE;
            end
            if (start_pend) begin
                pend_v <= 1'b0;
            end else if (take_q) begin
                pend_v <= 1'b1;
                pend   <= inc;
            end
        end
    end

    assign mem_req   = running && (req_cnt != cur.len);
    assign mem_addr  = cur.addr + AW'(req_cnt);
    assign wr_en     = running && mem_rvalid;
    assign wr_slot   = cur.base + rcv_cnt[SW-1:0];
    assign busy      = running || pend_v;
    assign cmd_ready = !pend_v;

    a_r4_busy_ends_on_write: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(wr_en));

    a_r5_queue_frozen: assert property (@(posedge clk) disable iff (rst)
        (pend_v && running) |=> (pend_v && $stable(pend)));

    a_r3_rsp_in_transfer: assert property (@(posedge clk) disable iff (rst)
        mem_rvalid |-> running);

    a_r10_zero_len_dropped: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_len == '0) && !busy) |=> !busy);

endmodule

// File: rtl/irf_store.sv
module irf_store
    import irf_pkg::*;
#(
    parameter int NSLOT = IRF_SLOTS_DEF,
    parameter int IW    = IRF_INSTR_W_DEF,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SW-1:0]    wr_slot,
    input  logic [IW-1:0]    wr_data,
    input  logic [NSLOT-1:0] clr_mask,
    input  logic [SW-1:0]    rd_slot,
    output logic [IW-1:0]    rd_data,
    output logic             rd_valid
);

    logic [IW-1:0]    slots [NSLOT];
    logic [NSLOT-1:0] valid;
    logic [NSLOT-1:0] wr_hot;

    for (genvar i = 0; i < NSLOT; i++) begin : g_hot
        assign wr_hot[i] = wr_en && (wr_slot == SW'(i));
    end

    // a clear from a starting transfer overrides a late write
    always_ff @(posedge clk) begin
        if (rst) valid <= '0;
        else     valid <= (valid | wr_hot) & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_slot] <= wr_data;
    end

    assign rd_data  = slots[rd_slot];
    assign rd_valid = valid[rd_slot];

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (|clr_mask) |=> ((valid & $past(clr_mask)) == '0));

    a_r3_write_sets_valid: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr_mask[wr_slot]) |=> valid[$past(wr_slot)]);

endmodule

// File: rtl/irf_seq.sv
module irf_seq
    import irf_pkg::*;
#(
    parameter int NSLOT = IRF_SLOTS_DEF,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_en,
    input  logic             redirect,
    input  logic [SW-1:0]    redirect_slot,
    input  logic             loop_on,
    input  logic [SW-1:0]    loop_start,
    input  logic [SW-1:0]    loop_end,
    input  logic             slot_valid,
    output logic [SW-1:0]    pc,
    output logic [NSLOT-1:0] act_mask,
    output logic             fetch_valid
);

    pc_act_e act;

    for (genvar i = 0; i < NSLOT; i++) begin : g_part
        assign act_mask[i] = !loop_on || in_window(i, int'(loop_start), int'(loop_end));
    end

    assign fetch_valid = fetch_en && slot_valid && act_mask[pc];

    always_comb begin
        if (redirect)                       act = PC_JUMP;
        else if (!fetch_valid)              act = PC_HOLD;
        else if (loop_on && pc == loop_end) act = PC_WRAP;
        else                                act = PC_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            case (act)
                PC_JUMP: pc <= redirect_slot;
                PC_WRAP: pc <= loop_start;
                PC_STEP: pc <= pc + SW'(1);
                default: pc <= pc;
            endcase
        end
    end

    a_r6_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (fetch_en && !slot_valid && !redirect) |=> $stable(pc));

    a_r7_loop_returns: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !redirect && loop_on && pc == loop_end) |=> (pc == $past(loop_start)));

    a_r7_step: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !redirect && !(loop_on && pc == loop_end)) |=> (pc == $past(pc) + SW'(1)));

    a_r8_redirect_wins: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (pc == $past(redirect_slot)));

endmodule

// File: rtl/irf_top.sv
module irf_top
    import irf_pkg::*;
#(
    parameter int NSLOT = IRF_SLOTS_DEF,
    parameter int AW    = IRF_ADDR_W_DEF,
    parameter int IW    = IRF_INSTR_W_DEF,
    localparam int SW   = $clog2(NSLOT),
    localparam int LW   = SW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [SW-1:0]    cmd_base,
    input  logic [LW-1:0]    cmd_len,
    output logic             cmd_ready,
    output logic             busy,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [IW-1:0]    mem_rdata,
    input  logic             fetch_en,
    input  logic             redirect,
    input  logic [SW-1:0]    redirect_slot,
    input  logic             loop_on,
    input  logic [SW-1:0]    loop_start,
    input  logic [SW-1:0]    loop_end,
    output logic             fetch_valid,
    output logic [SW-1:0]    fetch_slot,
    output logic [IW-1:0]    fetch_instr,
    output logic [NSLOT-1:0] active_mask
);

    logic             wr_en;
    logic [SW-1:0]    wr_slot;
    logic [NSLOT-1:0] clr_mask;
    logic [SW-1:0]    pc;
    logic             slot_ok;

    irf_xfer #(.NSLOT(NSLOT), .AW(AW)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_addr   (cmd_addr),
        .cmd_base   (cmd_base),
        .cmd_len    (cmd_len),
        .cmd_ready  (cmd_ready),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .clr_mask   (clr_mask)
    );

    irf_store #(.NSLOT(NSLOT), .IW(IW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_data  (mem_rdata),
        .clr_mask (clr_mask),
        .rd_slot  (pc),
        .rd_data  (fetch_instr),
        .rd_valid (slot_ok)
    );

    irf_seq #(.NSLOT(NSLOT)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .fetch_en      (fetch_en),
        .redirect      (redirect),
        .redirect_slot (redirect_slot),
        .loop_on       (loop_on),
        .loop_start    (loop_start),
        .loop_end      (loop_end),
        .slot_valid    (slot_ok),
        .pc            (pc),
        .act_mask      (active_mask),
        .fetch_valid   (fetch_valid)
    );

    assign fetch_slot = pc;

endmodule

// File: tb/irf_top_bench.sv
`timescale 1ns/1ps
module irf_top_bench;

    localparam int NS = 16;
    localparam int AW = 16;
    localparam int IW = 32;
    localparam int SW = 4;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [SW-1:0] cmd_base = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_ready;
    logic          busy;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [IW-1:0] mem_rdata;
    logic          fetch_en = 1'b1;
    logic          redirect = 1'b0;
    logic [SW-1:0] redirect_slot = '0;
    logic          loop_on = 1'b0;
    logic [SW-1:0] loop_start = '0;
    logic [SW-1:0] loop_end = '0;
    logic          fetch_valid;
    logic [SW-1:0] fetch_slot;
    logic [IW-1:0] fetch_instr;
    logic [NS-1:0] active_mask;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [IW-1:0] model [NS];

    // backing memory: two-cycle in-order pipeline
    logic          s0_v = 1'b0, s1_v = 1'b0;
    logic [AW-1:0] s0_a = '0, s1_a = '0;
    int            req_seen = 0;
    logic [AW-1:0] first_req = '0, last_req = '0;

    always #2 clk = ~clk;

    function automatic logic [IW-1:0] mdata(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, a};
    endfunction

    always_ff @(posedge clk) begin
        s0_v <= mem_req;
        s0_a <= mem_addr;
        s1_v <= s0_v;
        s1_a <= s0_a;
        if (mem_req) begin
            if (req_seen == 0) first_req <= mem_addr;
            last_req <= mem_addr;
            req_seen <= req_seen + 1;
        end
    end
    assign mem_rvalid = s1_v;
    assign mem_rdata  = mdata(s1_a);

    irf_top #(.NSLOT(NS), .AW(AW), .IW(IW)) u_irf_top (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_base(cmd_base), .cmd_len(cmd_len), .cmd_ready(cmd_ready), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .fetch_en(fetch_en), .redirect(redirect),
        .redirect_slot(redirect_slot), .loop_on(loop_on), .loop_start(loop_start),
        .loop_end(loop_end), .fetch_valid(fetch_valid), .fetch_slot(fetch_slot),
        .fetch_instr(fetch_instr), .active_mask(active_mask)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill_model(input logic [AW-1:0] a, input int b, input int l);
        for (int k = 0; k < l; k++) model[(b + k) % NS] = mdata(a + AW'(k));
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic read_slot(input int s, input string tag);
        @(negedge clk);
        redirect = 1'b1;
        redirect_slot = SW'(s);
        @(negedge clk);
        redirect = 1'b0;
        #1;
        chk(fetch_valid && fetch_slot == SW'(s) && fetch_instr == model[s], tag,
            fetch_instr, model[s]);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R4 watchdog: run hung actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(cmd_ready == 1'b1, "R1 cmd_ready after reset", cmd_ready, 1);
        chk(fetch_valid == 1'b0, "R1 fetch_valid after reset", fetch_valid, 0);
        chk(fetch_slot == '0, "R1 fetch_slot after reset", fetch_slot, 0);
        chk(active_mask == '1, "R9 mask without loop", active_mask, 16'hFFFF);

        // R3/R4 full fill
        req_seen = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = 16'h0100; cmd_base = 4'd0; cmd_len = 5'd16;
        @(negedge clk);
        cmd_valid = 1'b0;
        cnt = 0;
        while (busy && cnt < 100) begin cnt++; @(negedge clk); end
        chk(cnt == 18, "R4 busy length for len 16", cnt, 18);
        chk(req_seen == 16, "R3 request count", req_seen, 16);
        chk(first_req == 16'h0100 && last_req == 16'h010F, "R3 request addresses",
            {first_req, last_req}, 32'h0100010F);
        fill_model(16'h0100, 0, 16);

        // R6/R7 sequential sweep with wrap
        @(negedge clk);
        redirect = 1'b1; redirect_slot = 4'd0;
        @(negedge clk);
        redirect = 1'b0;
        for (int k = 0; k < 18; k++) begin
            #1;
            chk(fetch_valid && fetch_slot == SW'(k % NS) && fetch_instr == model[k % NS],
                "R7 sequential step and wrap", fetch_slot, k % NS);
            @(negedge clk);
        end

        // R2/R6 stall on a slot being reloaded
        cmd_valid = 1'b1; cmd_addr = 16'h0300; cmd_base = 4'd0; cmd_len = 5'd4;
        redirect = 1'b1; redirect_slot = 4'd2;
        @(negedge clk);
        cmd_valid = 1'b0; redirect = 1'b0;
        cnt = 0;
        #1;
        while (!fetch_valid && cnt < 100) begin
            chk(fetch_slot == 4'd2, "R6 index holds while stalled", fetch_slot, 2);
            cnt++;
            @(negedge clk);
            #1;
        end
        chk(cnt == 5, "R2 R6 stall cycles until slot refilled", cnt, 5);
        chk(fetch_instr == mdata(16'h0302), "R6 refilled data", fetch_instr, mdata(16'h0302));
        wait_idle();
        fill_model(16'h0300, 0, 4);

        // R10 zero-length command
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = 16'h0700; cmd_base = 4'd2; cmd_len = 5'd0;
        redirect = 1'b1; redirect_slot = 4'd2;
        @(negedge clk);
        cmd_valid = 1'b0; redirect = 1'b0;
        #1;
        chk(busy == 1'b0, "R10 zero length keeps busy low", busy, 0);
        chk(fetch_valid && fetch_instr == model[2], "R10 zero length clears nothing",
            fetch_instr, model[2]);

        // R5 queue: A runs, B queued, C ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = 16'h0400; cmd_base = 4'd4; cmd_len = 5'd4;
        @(negedge clk);
        #1;
        chk(cmd_ready == 1'b1, "R5 ready with empty queue", cmd_ready, 1);
        cmd_addr = 16'h0500; cmd_base = 4'd8; cmd_len = 5'd3;
        @(negedge clk);
        #1;
        chk(cmd_ready == 1'b0, "R5 not ready with full queue", cmd_ready, 0);
        cmd_addr = 16'h0600; cmd_base = 4'd12; cmd_len = 5'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        cnt = 0;
        while (busy && cnt < 100) begin cnt++; @(negedge clk); end
        chk(cnt == 10, "R4 R5 busy across queued transfer", cnt, 10);
        fill_model(16'h0400, 4, 4);
        fill_model(16'h0500, 8, 3);
        for (int s = 4; s < 14; s++) read_slot(s, "R5 queued and ignored commands");

        // R7/R9 loop partition
        @(negedge clk);
        loop_on = 1'b1; loop_start = 4'd3; loop_end = 4'd6;
        redirect = 1'b1; redirect_slot = 4'd3;
        #1;
        chk(active_mask == 16'h0078, "R9 partition mask", active_mask, 16'h0078);
        @(negedge clk);
        redirect = 1'b0;
        for (int k = 0; k < 10; k++) begin
            #1;
            chk(fetch_valid && fetch_slot == SW'(3 + k % 4) && fetch_instr == model[3 + k % 4],
                "R7 loop wraps to start", fetch_slot, 3 + k % 4);
            @(negedge clk);
        end
        redirect = 1'b1; redirect_slot = 4'd9;
        @(negedge clk);
        redirect = 1'b0;
        #1;
        chk(!fetch_valid && fetch_slot == 4'd9, "R9 outside partition not fetched",
            fetch_valid, 0);
        @(negedge clk);
        loop_on = 1'b0;
        #1;
        chk(fetch_valid && active_mask == '1, "R9 partition released", fetch_valid, 1);

        // R2/R3 sweep of every base with a wrapping length of 5
        for (int b = 0; b < NS; b++) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_addr = AW'(16'h0800 + b * 16); cmd_base = SW'(b);
            cmd_len = 5'd5;
            redirect = 1'b1; redirect_slot = SW'((b + 5) % NS);
            @(negedge clk);
            cmd_valid = 1'b0; redirect = 1'b0;
            #1;
            chk(fetch_valid && fetch_slot == SW'((b + 5) % NS),
                "R2 slot outside range stays valid", fetch_valid, 1);
            wait_idle();
            fill_model(AW'(16'h0800 + b * 16), b, 5);
            for (int s = 0; s < NS; s++) read_slot(s, "R3 sweep slot contents");
        end

        finish_run();
    end

endmodule